// File: doc/BRIEF.md
# Endpoint FIFO Bus Port with Longword Read-Ahead

This block is the processor-facing slave that moves data between a register bus and a set of per-endpoint USB data FIFOs. The bus master selects an endpoint by its data-register word address, gives an access size (8, 16 or 32 bits) and a direction, and holds the request until the block returns a one-cycle acknowledge. The block stretches every access with wait states so that its latency follows a fixed schedule, which depends on the size, the direction, the number of idle clocks before the request, and the recent access history.

After a 32-bit read, the block copies the following FIFO entry of that endpoint into a one-entry holding register. A later 32-bit read of the same endpoint then finishes sooner. Any access to another endpoint, and any access that is not a 32-bit read, discards the held entry. The same history also makes back-to-back 32-bit writes slower than spaced ones. The FIFOs here are simple behavioural queues of 32-bit entries, filled by bus writes and drained by bus reads, so the port can be exercised in loopback.

Top module: `epf_bus_port`

## Requirements
- R1: `ack` is high for exactly one cycle per access, never in the first request cycle. Read data is valid on `rdata` while `ack` is high. Each endpoint returns its entries in the order they were written.
- R2: A byte access (`size` = 2'b00) completes in 5 clocks for a read and in 4 clocks for a write. The request cycle counts as clock 1.
- R3: A 16-bit access (`size` = 2'b01) completes in 6 clocks for a read and in 4 clocks for a write.
- R4: A 32-bit read (`size[1]` = 1) that finds no held entry takes 8 clocks. The read that follows it, if it hits the held entry, takes 4 clocks back to back and 3 clocks after one or more idle clocks.
- R5: Further consecutive 32-bit read hits take 6, 5, 4 or 3 clocks after 0, 1, 2 or at least 3 idle clocks.
- R6: An access to an endpoint other than the last one accessed discards the held entry and the write history, so a 32-bit read there takes 8 clocks.
- R7: A 32-bit write takes 4 clocks unless the previous access was a 32-bit write to the same endpoint. In that case it takes 6 clocks back to back, 5 clocks after one idle clock and 4 clocks after two or more.
- R8: A read of an empty FIFO returns zero with unchanged timing and sets `underflow`. The flag stays set until reset.
- R9: After reset `ack` and `underflow` are low and no entry is held, so the first 32-bit read takes 8 clocks.
- R10: Byte and 16-bit reads return the low 8 or 16 bits of one FIFO entry, zero-extended, and remove that entry. Such writes store the low bits zero-extended as one entry. A non-32-bit access also discards the held entry.
- R11: A write to a full FIFO is acknowledged with normal timing and its data is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, held until `ack` |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 00 byte, 01 16-bit, 1x 32-bit |
| ep_addr | input | EPW | Endpoint data-register word address |
| wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle completion strobe |
| rdata | output | 32 | Read data, valid with `ack` |
| underflow | output | 1 | Sticky empty-read flag |

## Verification
The hardest states to reach are the later read-hit latencies. They need a run of 32-bit reads to one endpoint with at least two entries queued at every step, no intervening access of another size or endpoint, and a controlled idle gap. The bench fills an endpoint to depth and then drains it with a directed sequence of gaps 0, 0, 1, 2, 3 and larger. Random traffic uses a small endpoint count and gaps from 0 to 4, so streaks of both kinds also occur there, with underflow and full-FIFO drops mixed in.

// File: rtl/epf_pkg.sv
// Package epf_pkg
// Shared types and timing rules for the endpoint FIFO bus port.
// Assumes 32-bit FIFO entries and a two-bit access size code.
package epf_pkg;

    localparam int DW = 32;

    typedef enum logic { ST_IDLE, ST_BUSY } port_st_t;

    // Read history used by the latency rules
    typedef enum logic [1:0] { RS_NONE, RS_MISS, RS_HIT } rd_streak_t;

    // Keep only the bits the access size carries, zero-extended
    function automatic logic [DW-1:0] size_mask(input logic [DW-1:0] d, input logic [1:0] sz);
        logic [DW-1:0] r;
        case (sz)
            2'b00:   r = {24'd0, d[7:0]};
            2'b01:   r = {16'd0, d[15:0]};
            default: r = d;
        endcase
        return r;
    endfunction

    // Total access length in clocks, request cycle included
    function automatic logic [3:0] access_clocks(
        input logic       wr,
        input logic [1:0] sz,
        input logic       pf_hit,
        input rd_streak_t streak,
        input logic       wr_streak,
        input logic [1:0] gap
    );
        logic [3:0] l;
        if (wr) begin
            if (sz[1] && wr_streak)
                l = (gap == 2'd0) ? 4'd6 : (gap == 2'd1) ? 4'd5 : 4'd4;
            else
                l = 4'd4;
        end else if (sz == 2'b00) begin
            l = 4'd5;
        end else if (sz == 2'b01) begin
            l = 4'd6;
        end else if (!pf_hit) begin
            l = 4'd8;
        end else if (streak == RS_MISS) begin
            l = (gap == 2'd0) ? 4'd4 : 4'd3;
        end else begin
            l = 4'd6 - {2'd0, gap};
        end
        return l;
    endfunction

endpackage

// File: rtl/epf_fifo.sv
// Module epf_fifo
// Behavioural single-endpoint FIFO of 32-bit entries. It exposes the head
// entry and the one behind it so that the port can read ahead.
// Assumes DEPTH is a power of two and never sees push on full or pop on empty.
module epf_fifo #(
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [31:0]   push_data,
    input  logic          pop,
    output logic [31:0]   head,
    output logic [31:0]   head_next,
    output logic          empty,
    output logic          full,
    output logic          multi
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [31:0]   mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] count;

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Entry storage
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Status and read-side views
    always_comb begin
        empty     = (count == '0);
        full      = (count == CW'(DEPTH));
        multi     = (count > CW'(1));
        head      = mem[rd_ptr];
        head_next = mem[rd_ptr + 1'b1];
    end

endmodule

// File: rtl/epf_readahead.sv
// Module epf_readahead
// Holds the read-ahead longword, the read and write streak history, and the
// last endpoint accessed. History is discarded on an endpoint change.
// Assumes start and done never occur in the same cycle.
module epf_readahead
    import epf_pkg::*;
#(
    parameter int EPW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            done,
    input  logic [EPW-1:0]  ep,
    input  logic            rd_long,
    input  logic            wr_long,
    input  logic            next_avail,
    input  logic [31:0]     next_data,
    output logic            pf_hit,
    output rd_streak_t      rd_streak,
    output logic            wr_streak,
    output logic [31:0]     pf_data
);
    logic           pf_valid;
    rd_streak_t     streak_q;
    logic           wstreak_q;
    logic [EPW-1:0] last_ep;
    logic           last_valid;
    logic           hit_lat;
    logic           same_ep;

    // Effective history for the access being started
    always_comb begin
        same_ep   = last_valid && (last_ep == ep);
        pf_hit    = rd_long && pf_valid && same_ep;
        rd_streak = same_ep ? streak_q : RS_NONE;
        wr_streak = same_ep && wstreak_q;
    end

    // History update at access start and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid   <= 1'b0;
            streak_q   <= RS_NONE;
            wstreak_q  <= 1'b0;
            last_ep    <= '0;
            last_valid <= 1'b0;
            hit_lat    <= 1'b0;
        end else if (start) begin
            hit_lat    <= pf_hit;
            last_ep    <= ep;
            last_valid <= 1'b1;
            if (!same_ep) begin
                pf_valid  <= 1'b0;
                streak_q  <= RS_NONE;
                wstreak_q <= 1'b0;
            end
        end else if (done) begin
            wstreak_q <= wr_long;
            if (rd_long) begin
                pf_valid <= next_avail;
                streak_q <= hit_lat ? RS_HIT : RS_MISS;
            end else begin
                pf_valid <= 1'b0;
                streak_q <= RS_NONE;
            end
        end
    end

    // Holding register for the next longword
    always_ff @(posedge clk) begin
        if (!rst_n)                pf_data <= '0;
        else if (done && rd_long)  pf_data <= next_data;
    end

endmodule

// File: rtl/epf_latency.sv
// Module epf_latency
// Combinational access-length lookup for the access being started.
// Assumes gap is already saturated at three.
module epf_latency
    import epf_pkg::*;
(
    input  logic        wr,
    input  logic [1:0]  size,
    input  logic        pf_hit,
    input  rd_streak_t  rd_streak,
    input  logic        wr_streak,
    input  logic [1:0]  gap,
    output logic [3:0]  clocks
);
    // Select the length from size, direction, history and gap
    always_comb begin
        clocks = access_clocks(wr, size, pf_hit, rd_streak, wr_streak, gap);
    end

endmodule

// File: rtl/epf_bus_port.sv
// Module epf_bus_port
// Bus slave for several endpoint data FIFOs. It inserts wait states to a
// fixed schedule and reads one longword ahead per endpoint.
// Assumes the master holds req, wr, size, ep_addr and wdata stable until ack.
module epf_bus_port
    import epf_pkg::*;
#(
    parameter  int NUM_EP     = 4,
    parameter  int FIFO_DEPTH = 8,
    localparam int EPW        = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            wr,
    input  logic [1:0]      size,
    input  logic [EPW-1:0]  ep_addr,
    input  logic [31:0]     wdata,
    output logic            ack,
    output logic [31:0]     rdata,
    output logic            underflow
);
    localparam int CNTW = 3;

    port_st_t    st;
    logic [CNTW-1:0] cnt;
    logic [1:0]  gap;
    logic [31:0] rdata_q;
    logic        uf_q;
    logic        start;
    logic        done;
    logic        rd_long;
    logic        wr_long;
    logic [3:0]  clocks;
    logic        pf_hit;
    rd_streak_t  rd_streak;
    logic        wr_streak;
    logic [31:0] pf_data;

    logic [31:0] f_head  [NUM_EP];
    logic [31:0] f_next  [NUM_EP];
    logic        f_empty [NUM_EP];
    logic        f_full  [NUM_EP];
    logic        f_multi [NUM_EP];

    logic [31:0] sel_head;
    logic [31:0] sel_next;
    logic        sel_empty;
    logic        sel_multi;
    logic [31:0] rd_value;

    // Access control strobes and endpoint selection
    always_comb begin
        start     = (st == ST_IDLE) && req;
        done      = (st == ST_BUSY) && (cnt == '0);
        rd_long   = !wr && size[1];
        wr_long   = wr && size[1];
        sel_head  = f_head[ep_addr];
        sel_next  = f_next[ep_addr];
        sel_empty = f_empty[ep_addr];
        sel_multi = f_multi[ep_addr];
        if (pf_hit)         rd_value = pf_data;
        else if (sel_empty) rd_value = '0;
        else                rd_value = sel_head;
    end

    // One behavioural FIFO per endpoint
    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        logic hit_me;
        assign hit_me = (ep_addr == EPW'(g));
        epf_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (done && wr && hit_me && !f_full[g]),
            .push_data (size_mask(wdata, size)),
            .pop       (done && !wr && hit_me && !f_empty[g]),
            .head      (f_head[g]),
            .head_next (f_next[g]),
            .empty     (f_empty[g]),
            .full      (f_full[g]),
            .multi     (f_multi[g])
        );
    end

    epf_readahead #(.EPW(EPW)) u_ra (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .done       (done),
        .ep         (ep_addr),
        .rd_long    (rd_long),
        .wr_long    (wr_long),
        .next_avail (sel_multi),
        .next_data  (sel_next),
        .pf_hit     (pf_hit),
        .rd_streak  (rd_streak),
        .wr_streak  (wr_streak),
        .pf_data    (pf_data)
    );

    epf_latency u_lat (
        .wr        (wr),
        .size      (size),
        .pf_hit    (pf_hit),
        .rd_streak (rd_streak),
        .wr_streak (wr_streak),
        .gap       (gap),
        .clocks    (clocks)
    );

    // Wait-state sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else if (start) begin
            st  <= ST_BUSY;
            cnt <= CNTW'(clocks - 4'd2);
        end else if (done) begin
            st  <= ST_IDLE;
        end else if (st == ST_BUSY) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Idle-gap counter, saturating at three
    always_ff @(posedge clk) begin
        if (!rst_n || done)                         gap <= 2'd0;
        else if (st == ST_IDLE && !req && gap != 2'd3) gap <= gap + 2'd1;
    end

    // Read data capture at access start
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (start) rdata_q <= wr ? 32'd0 : size_mask(rd_value, size);
    end

    // Sticky empty-read flag
    always_ff @(posedge clk) begin
        if (!rst_n)                        uf_q <= 1'b0;
        else if (done && !wr && sel_empty) uf_q <= 1'b1;
    end

    assign ack       = done;
    assign rdata     = rdata_q;
    assign underflow = uf_q;

endmodule

// File: rtl/epf_port_chk.sv
// Module epf_port_chk
// Port-level timing checker bound to epf_bus_port. It counts request
// cycles itself and checks access lengths and flag behaviour.
module epf_port_chk #(
    parameter int EPW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req,
    input logic           wr,
    input logic [1:0]     size,
    input logic [EPW-1:0] ep_addr,
    input logic           ack,
    input logic           underflow
);
    logic [3:0]     len;
    logic [EPW-1:0] prev_ep;
    logic           prev_v;

    // Request cycles before the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n || ack)           len <= 4'd0;
        else if (req && len != 4'hF) len <= len + 4'd1;
    end

    // Endpoint of the last completed access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_v  <= 1'b0;
            prev_ep <= '0;
        end else if (ack) begin
            prev_v  <= 1'b1;
            prev_ep <= ep_addr;
        end
    end

    p_ack_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    p_ack_with_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> req);
    p_byte_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && size == 2'b00) |-> (len == (wr ? 4'd3 : 4'd4)));
    p_half_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && size == 2'b01) |-> (len == (wr ? 4'd3 : 4'd5)));
    p_new_ep_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr && size[1] && (!prev_v || prev_ep != ep_addr)) |-> (len == 4'd7));
    p_long_write_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && wr && size[1]) |-> (len >= 4'd3 && len <= 4'd5));
    p_uf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    p_long_read_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr && size[1]) |-> (len >= 4'd2 && len <= 4'd7 && len != 4'd6));

endmodule

bind epf_bus_port epf_port_chk #(.EPW(EPW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .wr        (wr),
    .size      (size),
    .ep_addr   (ep_addr),
    .ack       (ack),
    .underflow (underflow)
);

// File: tb/sim_epf_bus_port.sv
`timescale 1ns/1ps
// Bench for epf_bus_port: directed corner sequences plus seeded random
// traffic, checked against a reference model kept in the bench.
module sim_epf_bus_port;
    localparam int NEP = 4;
    localparam int DEP = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic        wr;
    logic [1:0]  size;
    logic [1:0]  ep_addr;
    logic [31:0] wdata;
    logic        ack;
    logic [31:0] rdata;
    logic        underflow;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state
    logic [31:0] mq [NEP][DEP];
    int  mh [NEP];
    int  mc [NEP];
    bit  m_pf;
    int  m_st;
    bit  m_ws;
    int  m_last;
    bit  m_lv;
    bit  m_uf;
    bit  m_nl;

    always #2 clk = ~clk;

    epf_bus_port #(.NUM_EP(NEP), .FIFO_DEPTH(DEP)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .size(size),
        .ep_addr(ep_addr), .wdata(wdata), .ack(ack), .rdata(rdata),
        .underflow(underflow)
    );

    function automatic logic [31:0] msk(input logic [31:0] d, input logic [1:0] s);
        if (s == 2'b00) return {24'd0, d[7:0]};
        if (s == 2'b01) return {16'd0, d[15:0]};
        return d;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // One bus access after g idle clocks, checked against the model
    task automatic access(input bit w, input logic [1:0] s, input int e,
                          input logic [31:0] d, input int g);
        int gs; int lat; int cyc; bit same; bit hit; bit was_empty;
        logic [31:0] exp_d; logic [31:0] got; string tag;
        repeat (g) begin @(negedge clk); req = 1'b0; end
        @(negedge clk);
        req = 1'b1; wr = w; size = s; ep_addr = 2'(e); wdata = d;
        gs   = (g > 3) ? 3 : g;
        same = m_lv && (e == m_last);
        if (!same) begin m_pf = 0; m_st = 0; m_ws = 0; end
        hit  = !w && s[1] && m_pf;
        if (w) begin
            lat = (s[1] && m_ws) ? ((gs == 0) ? 6 : (gs == 1) ? 5 : 4) : 4;
            tag = s[1] ? "R7" : (s == 2'b00) ? "R2" : "R3";
        end else if (s == 2'b00) begin
            lat = 5; tag = "R2";
        end else if (s == 2'b01) begin
            lat = 6; tag = "R3";
        end else if (hit) begin
            if (m_st == 1) begin lat = (gs == 0) ? 4 : 3; tag = "R4"; end
            else begin lat = 6 - gs; tag = "R5"; end
        end else begin
            lat = 8;
            tag = !same ? "R6" : m_nl ? "R10" : "R4";
        end
        was_empty = (mc[e] == 0);
        exp_d = was_empty ? 32'd0 : msk(mq[e][mh[e]], s);
        #1;
        chk(ack == 1'b0, "R1", "ack in request cycle", ack, 0);
        cyc = 1;
        while (!ack && cyc < 30) begin @(negedge clk); #1; cyc++; end
        got = rdata;
        chk(cyc == lat, tag, "access clocks", cyc, lat);
        if (!w) chk(got == exp_d, was_empty ? "R8" : (s[1] ? "R1" : "R10"),
                    "read data", got, exp_d);
        chk(underflow == m_uf, "R8", "underflow flag", underflow, m_uf);
        // model update
        if (w) begin
            if (mc[e] < DEP) begin
                mq[e][(mh[e] + mc[e]) % DEP] = msk(d, s);
                mc[e]++;
            end
            m_ws = s[1]; m_pf = 0; m_st = 0;
        end else begin
            if (was_empty) m_uf = 1;
            else begin mh[e] = (mh[e] + 1) % DEP; mc[e]--; end
            if (s[1]) begin m_pf = (mc[e] >= 1); m_st = hit ? 2 : 1; end
            else begin m_pf = 0; m_st = 0; end
            m_ws = 0;
        end
        m_nl = !s[1]; m_last = e; m_lv = 1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); req = 1'b0; end
    endtask

    // Watchdog
    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NEP; i++) begin mh[i] = 0; mc[i] = 0; end
        m_pf = 0; m_st = 0; m_ws = 0; m_last = 0; m_lv = 0; m_uf = 0; m_nl = 0;
        rst_n = 1'b0; req = 1'b0; wr = 1'b0; size = 2'b00; ep_addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(ack == 1'b0, "R9", "ack after reset", ack, 0);
        chk(underflow == 1'b0, "R9", "underflow after reset", underflow, 0);

        // R9 / R11 / R7: fill endpoint 1, then a dropped write
        access(1, 2'b10, 1, 32'hA000_0001, 2);
        access(1, 2'b10, 1, 32'hA000_0002, 0);
        access(1, 2'b10, 1, 32'hA000_0003, 1);
        access(1, 2'b10, 1, 32'hA000_0004, 2);
        access(1, 2'b10, 1, 32'hA000_0005, 0);
        access(1, 2'b10, 1, 32'hA000_0006, 0);
        access(1, 2'b10, 1, 32'hA000_0007, 3);
        access(1, 2'b10, 1, 32'hA000_0008, 0);
        access(1, 2'b10, 1, 32'hDEAD_BEEF, 0); // R11: full, dropped

        // R4 / R5: drain endpoint 1 with each gap
        access(0, 2'b10, 1, 0, 1);
        access(0, 2'b10, 1, 0, 0);
        access(0, 2'b10, 1, 0, 0);
        access(0, 2'b10, 1, 0, 1);
        access(0, 2'b10, 1, 0, 2);
        access(0, 2'b10, 1, 0, 3);
        access(0, 2'b10, 1, 0, 5);
        access(0, 2'b10, 1, 0, 0);
        // R8: empty read
        access(0, 2'b10, 1, 0, 0);
        access(0, 2'b00, 1, 0, 2);

        // R6 and R4 with gap: endpoint change discards the held entry
        access(1, 2'b10, 2, 32'hB000_0001, 1);
        access(1, 2'b10, 2, 32'hB000_0002, 0);
        access(1, 2'b10, 2, 32'hB000_0003, 0);
        access(0, 2'b10, 2, 0, 1);
        access(0, 2'b10, 2, 0, 1);   // hit after miss, gap 1 -> 3
        access(1, 2'b00, 3, 32'h1234_56AB, 0);
        access(0, 2'b10, 2, 0, 0);   // R6: back on endpoint 2 -> 8

        // R10: sizes and non-longword access clears read-ahead
        access(1, 2'b01, 3, 32'h9876_CAFE, 0);
        access(1, 2'b10, 3, 32'h0F0F_0F0F, 0);
        access(1, 2'b10, 3, 32'h7070_7070, 0);
        access(0, 2'b00, 3, 0, 0);
        access(0, 2'b01, 3, 0, 1);
        access(0, 2'b10, 3, 0, 0);
        access(0, 2'b00, 3, 0, 0);
        access(1, 2'b10, 3, 32'h5555_AAAA, 0);
        access(1, 2'b10, 3, 32'h6666_BBBB, 0);
        access(0, 2'b10, 3, 0, 2);
        access(0, 2'b01, 3, 0, 0);
        access(0, 2'b10, 3, 0, 0);   // R10: miss after 16-bit read

        // Random traffic
        for (int i = 0; i < 500; i++) begin
            int e; int r; bit w;
            e = int'($urandom % NEP);
            w = ($urandom % 5) < 2;
            r = int'($urandom % 4);
            access(w, 2'(r), e, $urandom, int'($urandom % 5));
        end
        idle(3);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule